// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the decision core of an on-chip debug trigger. It watches match events produced by address and data comparators elsewhere in the debug logic. Each event can come in two ways. A forced hit acts at once. A tagged hit is only a candidate until the tagged instruction is seen to execute. Based on a small per-state configuration, the block walks through a short chain of states. When it reaches its final state it starts trace capture, raises a breakpoint request to the processor, or does both. Software can also skip the chain entirely and jump straight to the final state.

The sequencer has four states. IDLE is the only state allowed while the block is disarmed. STAGE1 and STAGE2 are the two waiting states. Each waiting state watches one comparator chosen by configuration. On a hit it either goes to the other waiting state or goes to FINAL, again according to configuration. FINAL is held until the arm input drops. These are the transitions:

- arm (IDLE to STAGE1)
- stage advance (STAGE1 to STAGE2, or STAGE2 to STAGE1)
- stage fire (STAGE1 or STAGE2 to FINAL)
- software fire (any armed state other than FINAL to FINAL)
- disarm (any state to IDLE)

When the device runs in secure mode, breakpoints still work, but trace enable is held low.

Top module: `dbg_trig_seq`

## Requirements
- R1: While `arm_i` is low, the state returns to IDLE at the next clock edge. In the same step `trace_en_o` goes low, `cause_o` becomes 0, and all pending tags are discarded.
- R2: The state codes are IDLE=0, STAGE1=1, STAGE2=2 and FINAL=3. When the block is armed and in IDLE, it moves to STAGE1 at the next edge.
- R3: In STAGE1 or STAGE2, a forced hit on the comparator picked by that state's select field changes state at the edge that ends the hit cycle. If the go-final bit is 1 the new state is FINAL. If it is 0 the new state is the other waiting state. Hits on comparators that are not selected are ignored.
- R4: A `tag_hit_i` bit marks its comparator as pending. A pending tag acts like a hit only in a cycle where `tag_exec_i` is high and `tag_flush_i` is low, and the state then changes at that cycle's edge. A flush discards all pending tags, and flush has priority over exec in the same cycle.
- R5: When armed, a `sw_trig_i` pulse moves any state except FINAL to FINAL at the next edge. It takes priority over a hit in the same cycle. It is ignored while the block is disarmed.
- R6: `bkpt_req_o` is high for exactly one cycle: the first cycle in which `state_o` reads FINAL. It is only raised if `bkpt_en_i` was high when FINAL was entered. Staying in FINAL raises no further pulse.
- R7: `trace_en_o` is high while in FINAL, but only if `trace_cfg_i` was high and `secure_i` was low at entry. It is low in every cycle in which `secure_i` is high. Secure mode does not block `bkpt_req_o`.
- R8: `cause_o` records why FINAL was entered: 0 means not in FINAL, 1 a forced hit, 2 a confirmed tag, 3 software. If a forced hit and a confirmed tag hit together, the cause is 1.
- R9: Once in FINAL, the state stays FINAL while armed, whatever the hits or software triggers.
- R10: Hits never move the state out of IDLE, whether the block is armed or disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arms the sequencer; low forces IDLE |
| sw_trig_i | input | 1 | Software trigger pulse |
| forced_hit_i | input | NUM_CMP | Forced-match pulses, one per comparator |
| tag_hit_i | input | NUM_CMP | Tagged-match marks, one per comparator |
| tag_exec_i | input | 1 | A tagged instruction reached execution |
| tag_flush_i | input | 1 | Instruction queue flushed; drop tags |
| secure_i | input | 1 | Secure mode; trace is blocked |
| s1_cmp_sel_i | input | SEL_W | Comparator watched in STAGE1 |
| s1_go_final_i | input | 1 | STAGE1 hit goes to FINAL (else STAGE2) |
| s2_cmp_sel_i | input | SEL_W | Comparator watched in STAGE2 |
| s2_go_final_i | input | 1 | STAGE2 hit goes to FINAL (else STAGE1) |
| bkpt_en_i | input | 1 | Allow a breakpoint on FINAL entry |
| trace_cfg_i | input | 1 | Allow trace on FINAL entry |
| state_o | output | 2 | Current state code |
| trace_en_o | output | 1 | Trace capture enable |
| bkpt_req_o | output | 1 | Breakpoint request pulse |
| cause_o | output | 2 | Reason FINAL was entered |

## Verification
Every result is registered once behind its cause. A forced hit, software trigger or disarm presented in cycle n shows on `state_o`, `bkpt_req_o` and `cause_o` in cycle n+1. A tagged hit is first stored at one edge, and its effect appears only in the cycle after the exec cycle. `trace_en_o` follows the state register, but `secure_i` also masks it combinationally in the same cycle. The bench drives one table row at a falling edge and compares all four outputs at the next falling edge, with that row's inputs still applied. This lands exactly one rising edge after the stimulus, and lets the combinational secure masking be seen in the row that sets it.

// File: rtl/dbg_trig_seq_pkg.sv
package dbg_trig_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_STAGE1 = 2'd1,
        SEQ_STAGE2 = 2'd2,
        SEQ_FINAL  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_FORCED = 2'd1,
        CAUSE_TAGGED = 2'd2,
        CAUSE_SW     = 2'd3
    } fire_cause_e;

endpackage

// File: rtl/dbg_tag_tracker.sv
module dbg_tag_tracker #(
    parameter int NUM_CMP = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm_i,
    input  logic [NUM_CMP-1:0] tag_hit_i,
    input  logic               exec_i,
    input  logic               flush_i,
    output logic [NUM_CMP-1:0] confirm_o
);

    logic [NUM_CMP-1:0] pend_q;
    logic               consume;

    // Pending tags are released when an instruction executes or when the queue is flushed.
    assign consume   = exec_i | flush_i;
    assign confirm_o = (exec_i && !flush_i) ? pend_q : '0;

    generate
        for (genvar k = 0; k < NUM_CMP; k++) begin : g_pend
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pend_q[k] <= 1'b0;
                end else if (!arm_i) begin
                    pend_q[k] <= 1'b0;
                end else if (consume) begin
                    pend_q[k] <= tag_hit_i[k];
                end else begin
                    pend_q[k] <= pend_q[k] | tag_hit_i[k];
                end
            end
        end
    endgenerate

    assert_pend_clear_disarm_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        !arm_i |=> (pend_q == '0)
    );

endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
    import dbg_trig_seq_pkg::*;
#(
    parameter int NUM_CMP = 3,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm_i,
    input  logic               sw_trig_i,
    input  logic [NUM_CMP-1:0] forced_hit_i,
    input  logic [NUM_CMP-1:0] tag_conf_i,
    input  logic [SEL_W-1:0]   s1_sel_i,
    input  logic               s1_final_i,
    input  logic [SEL_W-1:0]   s2_sel_i,
    input  logic               s2_final_i,
    output seq_state_e         state_o,
    output seq_state_e         state_next_o,
    output logic               enter_final_o,
    output fire_cause_e        enter_cause_o
);

    seq_state_e state_q;
    seq_state_e state_d;

    logic s1_forced, s1_tagged, s2_forced, s2_tagged;
    logic cur_forced, cur_tagged, cur_hit, cur_final;

    // Bit-pick with range guard: a select past the comparator count never hits.
    function automatic logic pick(input logic [NUM_CMP-1:0] vec, input logic [SEL_W-1:0] sel);
        logic r;
        r = 1'b0;
        for (int k = 0; k < NUM_CMP; k++) begin
            if (sel == SEL_W'(k)) r = vec[k];
        end
        return r;
    endfunction

    assign s1_forced = pick(forced_hit_i, s1_sel_i);
    assign s1_tagged = pick(tag_conf_i,   s1_sel_i);
    assign s2_forced = pick(forced_hit_i, s2_sel_i);
    assign s2_tagged = pick(tag_conf_i,   s2_sel_i);

    always_comb begin
        cur_forced = 1'b0;
        cur_tagged = 1'b0;
        cur_final  = 1'b0;
        if (state_q == SEQ_STAGE1) begin
            cur_forced = s1_forced;
            cur_tagged = s1_tagged;
            cur_final  = s1_final_i;
        end else if (state_q == SEQ_STAGE2) begin
            cur_forced = s2_forced;
            cur_tagged = s2_tagged;
            cur_final  = s2_final_i;
        end
    end

    assign cur_hit = cur_forced | cur_tagged;

    always_comb begin
        state_d = state_q;
        if (!arm_i) begin
            state_d = SEQ_IDLE;
        end else begin
            unique case (state_q)
                SEQ_IDLE:   state_d = sw_trig_i ? SEQ_FINAL : SEQ_STAGE1;
                SEQ_STAGE1: begin
                    if (sw_trig_i)    state_d = SEQ_FINAL;
                    else if (cur_hit) state_d = cur_final ? SEQ_FINAL : SEQ_STAGE2;
                end
                SEQ_STAGE2: begin
                    if (sw_trig_i)    state_d = SEQ_FINAL;
                    else if (cur_hit) state_d = cur_final ? SEQ_FINAL : SEQ_STAGE1;
                end
                SEQ_FINAL:  state_d = SEQ_FINAL;
                default:    state_d = SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        if (sw_trig_i)       enter_cause_o = CAUSE_SW;
        else if (cur_forced) enter_cause_o = CAUSE_FORCED;
        else if (cur_tagged) enter_cause_o = CAUSE_TAGGED;
        else                 enter_cause_o = CAUSE_NONE;
    end

    assign enter_final_o = (state_d == SEQ_FINAL) && (state_q != SEQ_FINAL);
    assign state_o       = state_q;
    assign state_next_o  = state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    assert_idle_when_disarmed_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        !arm_i |=> (state_q == SEQ_IDLE)
    );

    assert_sw_trigger_final_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (arm_i && sw_trig_i) |=> (state_q == SEQ_FINAL)
    );

    assert_final_holds_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (arm_i && state_q == SEQ_FINAL) |=> (state_q == SEQ_FINAL)
    );

endmodule

// File: rtl/dbg_seq_outputs.sv
module dbg_seq_outputs
    import dbg_trig_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        secure_i,
    input  logic        bkpt_en_i,
    input  logic        trace_cfg_i,
    input  seq_state_e  state_next_i,
    input  logic        enter_final_i,
    input  fire_cause_e enter_cause_i,
    output logic        bkpt_o,
    output logic        trace_o,
    output fire_cause_e cause_o
);

    logic        bkpt_q;
    logic        trace_q;
    fire_cause_e cause_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bkpt_q  <= 1'b0;
            trace_q <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            bkpt_q <= enter_final_i && bkpt_en_i;
            if (enter_final_i) begin
                trace_q <= trace_cfg_i && !secure_i;
                cause_q <= enter_cause_i;
            end else if (state_next_i != SEQ_FINAL) begin
                trace_q <= 1'b0;
                cause_q <= CAUSE_NONE;
            end
        end
    end

    assign bkpt_o  = bkpt_q;
    assign trace_o = trace_q && !secure_i;
    assign cause_o = cause_q;

    assert_bkpt_single_pulse_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        bkpt_q |=> !bkpt_q
    );

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
    import dbg_trig_seq_pkg::*;
#(
    parameter int NUM_CMP = 3,
    localparam int SEL_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm_i,
    input  logic               sw_trig_i,
    input  logic [NUM_CMP-1:0] forced_hit_i,
    input  logic [NUM_CMP-1:0] tag_hit_i,
    input  logic               tag_exec_i,
    input  logic               tag_flush_i,
    input  logic               secure_i,
    input  logic [SEL_W-1:0]   s1_cmp_sel_i,
    input  logic               s1_go_final_i,
    input  logic [SEL_W-1:0]   s2_cmp_sel_i,
    input  logic               s2_go_final_i,
    input  logic               bkpt_en_i,
    input  logic               trace_cfg_i,
    output logic [1:0]         state_o,
    output logic               trace_en_o,
    output logic               bkpt_req_o,
    output logic [1:0]         cause_o
);

    logic [NUM_CMP-1:0] tag_conf;
    seq_state_e         state_cur;
    seq_state_e         state_nxt;
    logic               enter_final;
    fire_cause_e        enter_cause;
    fire_cause_e        cause_cur;

    dbg_tag_tracker #(.NUM_CMP(NUM_CMP)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (arm_i),
        .tag_hit_i (tag_hit_i),
        .exec_i    (tag_exec_i),
        .flush_i   (tag_flush_i),
        .confirm_o (tag_conf)
    );

    dbg_seq_fsm #(.NUM_CMP(NUM_CMP), .SEL_W(SEL_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .arm_i         (arm_i),
        .sw_trig_i     (sw_trig_i),
        .forced_hit_i  (forced_hit_i),
        .tag_conf_i    (tag_conf),
        .s1_sel_i      (s1_cmp_sel_i),
        .s1_final_i    (s1_go_final_i),
        .s2_sel_i      (s2_cmp_sel_i),
        .s2_final_i    (s2_go_final_i),
        .state_o       (state_cur),
        .state_next_o  (state_nxt),
        .enter_final_o (enter_final),
        .enter_cause_o (enter_cause)
    );

    dbg_seq_outputs u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .secure_i      (secure_i),
        .bkpt_en_i     (bkpt_en_i),
        .trace_cfg_i   (trace_cfg_i),
        .state_next_i  (state_nxt),
        .enter_final_i (enter_final),
        .enter_cause_i (enter_cause),
        .bkpt_o        (bkpt_req_o),
        .trace_o       (trace_en_o),
        .cause_o       (cause_cur)
    );

    assign state_o = state_cur;
    assign cause_o = cause_cur;

    assert_trace_only_in_final_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        trace_en_o |-> (state_cur == SEQ_FINAL)
    );

    assert_bkpt_with_final_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        bkpt_req_o |-> (state_cur == SEQ_FINAL && $past(state_cur) != SEQ_FINAL)
    );

endmodule

// File: tb/tb_dbg_trig_seq.sv
`timescale 1ns/1ps
module tb_dbg_trig_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm, sw, exe, fl, sec, f1, f2, bk, tr;
    logic [2:0] frc, tag;
    logic [1:0] c1, c2;
    logic [1:0] state;
    logic       trace_en, bkpt;
    logic [1:0] cause;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dbg_trig_seq #(.NUM_CMP(3)) dut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .sw_trig_i(sw),
        .forced_hit_i(frc), .tag_hit_i(tag), .tag_exec_i(exe), .tag_flush_i(fl),
        .secure_i(sec), .s1_cmp_sel_i(c1), .s1_go_final_i(f1),
        .s2_cmp_sel_i(c2), .s2_go_final_i(f2), .bkpt_en_i(bk), .trace_cfg_i(tr),
        .state_o(state), .trace_en_o(trace_en), .bkpt_req_o(bkpt), .cause_o(cause)
    );

    typedef struct packed {
        logic [7:0] rq;
        logic       arm; logic sw; logic [2:0] frc; logic [2:0] tag;
        logic       exe; logic fl; logic sec;
        logic [1:0] c1;  logic f1; logic [1:0] c2; logic f2;
        logic       bk;  logic tr;
        logic [1:0] est; logic ebk; logic etr; logic [1:0] ecs;
    } vec_t;

    localparam int NV = 33;
    // rq, arm,sw,frc,tag,exe,fl,sec, c1,f1,c2,f2,bk,tr, est,ebk,etr,ecs
    localparam vec_t TBL [NV] = '{
        '{1, 0,0,0,0,0,0,0, 1,0,2,1,1,1, 0,0,0,0}, // R1 disarmed
        '{2, 1,0,0,0,0,0,0, 1,0,2,1,1,1, 1,0,0,0}, // R2 arm
        '{3, 1,0,1,0,0,0,0, 1,0,2,1,1,1, 1,0,0,0}, // R3 unselected hit
        '{3, 1,0,2,0,0,0,0, 1,0,2,1,1,1, 2,0,0,0}, // R3 advance
        '{3, 1,0,2,0,0,0,0, 1,0,2,1,1,1, 2,0,0,0}, // R3 unselected in stage2
        '{4, 1,0,0,4,0,0,0, 1,0,2,1,1,1, 2,0,0,0}, // R4 tag only
        '{4, 1,0,0,0,1,0,0, 1,0,2,1,1,1, 3,1,1,2}, // R4 exec fires
        '{6, 1,0,0,0,0,0,0, 1,0,2,1,1,1, 3,0,1,2}, // R6 no repeat
        '{7, 1,0,0,0,0,0,1, 1,0,2,1,1,1, 3,0,0,2}, // R7 secure masks
        '{9, 1,1,7,0,0,0,0, 1,0,2,1,1,1, 3,0,1,2}, // R9 hold
        '{1, 0,0,0,0,0,0,0, 1,0,2,1,1,1, 0,0,0,0}, // R1 disarm
        '{5, 1,1,0,0,0,0,0, 1,0,2,1,1,1, 3,1,1,3}, // R5 sw from idle
        '{1, 0,0,0,0,0,0,0, 1,0,2,1,1,1, 0,0,0,0}, // R1
        '{2, 1,0,0,0,0,0,0, 1,0,2,1,1,1, 1,0,0,0}, // R2
        '{4, 1,0,0,2,0,0,0, 1,0,2,1,1,1, 1,0,0,0}, // R4 tag
        '{4, 1,0,0,0,0,1,0, 1,0,2,1,1,1, 1,0,0,0}, // R4 flush
        '{4, 1,0,0,0,1,0,0, 1,0,2,1,1,1, 1,0,0,0}, // R4 exec, nothing pending
        '{4, 1,0,0,2,0,0,0, 1,0,2,1,1,1, 1,0,0,0}, // R4 tag
        '{4, 1,0,0,0,1,1,0, 1,0,2,1,1,1, 1,0,0,0}, // R4 flush beats exec
        '{4, 1,0,0,2,0,0,0, 1,0,2,1,1,1, 1,0,0,0}, // R4 tag
        '{7, 1,0,0,0,1,0,1, 1,1,2,1,1,1, 3,1,0,2}, // R7 secure entry, bkpt kept
        '{7, 1,0,0,0,0,0,0, 1,1,2,1,1,1, 3,0,0,2}, // R7 trace stays off
        '{1, 0,0,0,0,0,0,0, 1,0,2,1,1,1, 0,0,0,0}, // R1
        '{2, 1,0,0,0,0,0,0, 0,1,2,1,0,1, 1,0,0,0}, // R2
        '{5, 1,1,1,0,0,0,0, 0,1,2,1,0,1, 3,0,1,3}, // R5 sw beats forced, R6 no bkpt
        '{1, 0,0,0,0,0,0,0, 1,0,2,1,1,1, 0,0,0,0}, // R1
        '{2, 1,0,0,0,0,0,0, 1,0,2,1,1,1, 1,0,0,0}, // R2
        '{3, 1,0,1,0,0,0,0, 0,0,2,1,1,1, 2,0,0,0}, // R3 s1->s2
        '{3, 1,0,4,0,0,0,0, 0,0,2,0,1,1, 1,0,0,0}, // R3 s2->s1
        '{8, 1,0,1,0,0,0,0, 0,1,2,1,1,0, 3,1,0,1}, // R8 forced cause
        '{5, 0,1,0,0,0,0,0, 1,0,2,1,1,1, 0,0,0,0}, // R5 ignored disarmed
        '{10,0,0,7,0,0,0,0, 1,0,2,1,1,1, 0,0,0,0}, // R10 disarmed hits
        '{10,1,0,7,0,0,0,0, 1,0,2,1,1,1, 1,0,0,0}  // R10 armed idle hits
    };

    task automatic chk(input string what, input int rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        arm = v.arm; sw = v.sw; frc = v.frc; tag = v.tag; exe = v.exe; fl = v.fl;
        sec = v.sec; c1 = v.c1; f1 = v.f1; c2 = v.c2; f2 = v.f2; bk = v.bk; tr = v.tr;
    endtask

    task automatic check_all(input int rq, input int est, input int ebk, input int etr, input int ecs);
        chk("state", rq, int'(state), est);
        chk("bkpt",  rq, int'(bkpt),  ebk);
        chk("trace", rq, int'(trace_en), etr);
        chk("cause", rq, int'(cause), ecs);
    endtask

    initial begin : watchdog
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL R0 watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        apply(TBL[0]);
        arm = 1'b1; sw = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state: held idle even with arm and trigger driven
        check_all(1, 0, 0, 0, 0);
        apply(TBL[0]);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            @(negedge clk);
            check_all(int'(TBL[i].rq), int'(TBL[i].est), int'(TBL[i].ebk),
                      int'(TBL[i].etr), int'(TBL[i].ecs));
        end
        // R8 forced and tagged together: forced reported
        arm = 1; sw = 0; frc = 0; tag = 3'b001; exe = 0; fl = 0; sec = 0;
        c1 = 0; f1 = 1; c2 = 2; f2 = 1; bk = 1; tr = 1;
        @(negedge clk);
        chk("state", 8, int'(state), 1);
        tag = 0; exe = 1; frc = 3'b001;
        @(negedge clk);
        check_all(8, 3, 1, 1, 1);
        // R1 asynchronous reset from FINAL clears everything at once
        exe = 0; frc = 0;
        rst_n = 1'b0;
        #1;
        check_all(1, 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R6 breakpoint pulse lasts exactly one cycle after a software fire
        sw = 1;
        @(negedge clk);
        sw = 0;
        chk("bkpt", 6, int'(bkpt), 1);
        @(negedge clk);
        chk("bkpt", 6, int'(bkpt), 0);
        chk("state", 9, int'(state), 3);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule